// File: doc/BRIEF.md
# Pipelined Nine-Lane Dot-Product Engine

This block computes one output neuron of a convolution window per accepted group. A group is a set of `LANES` signed activations, the same number of signed weights and one signed bias, all presented together on one clock cycle. The engine forms every activation-weight product at once. It sums the products through a registered binary tree, adds the bias, and applies a rectifier. It then clamps the result to an unsigned output of `OW` bits.

The pipeline never stalls. A group can be offered on every cycle, and each accepted group produces exactly one result a fixed number of cycles later. The delay is one cycle to capture the group, one to multiply, `ceil(log2(LANES))` adder-tree levels, and one cycle for the bias and rectifier. With the default of nine lanes this is seven cycles.

Top module: `dotprod_pipe`

## Requirements
- R1: For an accepted group the result equals sum over lanes of activation*weight plus bias, computed exactly in signed two's complement before the rectifier and the clamp.
- R2: A group may be accepted on every cycle. Groups offered on consecutive cycles produce results on consecutive cycles, in the order they were offered.
- R3: A group sampled with `in_vld` high at clock edge k produces `out_vld` high, with its result on `out_data`, right after edge k+2+ceil(log2(LANES)). That is seven edges including k for LANES=9. Each group raises `out_vld` for exactly one cycle.
- R4: A negative pre-clamp result (including -1) is output as 0.
- R5: A result above 2^OW-1 is output as 2^OW-1, for example 9 lanes of (-128)*(-128) with OW=16 gives 65535.
- R6: The boundary values 0 and exactly 2^OW-1 pass through unchanged, and 2^OW is clamped to 2^OW-1.
- R7: While `in_vld` is low, the data, weight and bias buses are ignored: no `out_vld` results from those cycles.
- R8: `rst` is synchronous and active high. It clears every valid bit in the pipeline, so `out_vld` is 0 after reset and groups in flight at the reset edge never appear at the output.
- R9: Lane i occupies bits [i*AW +: AW] of `in_act` and [i*WW +: WW] of `in_wgt`. Each lane is an independent signed two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of valid state |
| in_vld | input | 1 | Group on the input buses is to be accepted this cycle |
| in_act | input | LANES*AW | Packed signed activations, lane 0 in the low bits |
| in_wgt | input | LANES*WW | Packed signed weights, lane 0 in the low bits |
| in_bias | input | BW | Signed bias shared by the group |
| out_vld | output | 1 | `out_data` carries the result of one group |
| out_data | output | OW | Rectified, clamped unsigned result |

## Verification
The hardest state to reach from the ports is a reset edge that arrives while several groups are still inside the multiplier and adder-tree registers. A naive bench only resets an empty pipeline. The stimulus fires three groups back to back, raises `rst` on the next cycle, empties the expected queue, and watches for the whole latency window that no stale result emerges. A burst afterwards shows that the pipeline recovers. The exact clamp boundaries are reached with chosen operand and bias values that land the sum on -1, 0, 2^OW-1 and 2^OW.

// File: rtl/dp_pkg.sv
package dp_pkg;

   // number of live operands at a given adder-tree level
   function automatic int nodes_at(input int n, input int lvl);
      return (n + (1 << lvl) - 1) >> lvl;
   endfunction

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dp_mul_bank.sv
module dp_mul_bank #(
   parameter int LANES = 9,
   parameter int AW    = 8,
   parameter int WW    = 8,
   parameter int SBW   = 16,
   localparam int PW   = AW + WW
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  vld_i,
   input  logic [LANES*AW-1:0]   act_i,
   input  logic [LANES*WW-1:0]   wgt_i,
   input  logic [SBW-1:0]        sb_i,
   output logic                  vld_o,
   output logic [LANES*PW-1:0]   prod_o,
   output logic [SBW-1:0]        sb_o
);

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         prod_o[i*PW +: PW] <= PW'($signed(act_i[i*AW +: AW]) * $signed(wgt_i[i*WW +: WW]));
      end
      sb_o <= sb_i;
   end

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

endmodule

// File: rtl/dp_add_tree.sv
module dp_add_tree #(
   parameter int LANES = 9,
   parameter int IW    = 16,
   parameter int SBW   = 16,
   localparam int LVLS = $clog2(LANES),
   localparam int OW   = IW + LVLS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic [LANES*IW-1:0]      opd_i,
   input  logic [SBW-1:0]           sb_i,
   output logic                     vld_o,
   output logic signed [OW-1:0]     sum_o,
   output logic [SBW-1:0]           sb_o
);

   for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
      localparam int CNT = dp_pkg::nodes_at(LANES, l);
      logic signed [OW-1:0] node [CNT];
      logic [SBW-1:0]       sb;
      logic                 v;

      if (l == 0) begin : g_src
         always_comb begin
            for (int i = 0; i < CNT; i++) begin
               node[i] = OW'($signed(opd_i[i*IW +: IW]));
            end
         end
         assign sb = sb_i;
         assign v  = vld_i;
      end else begin : g_add
         localparam int PREV = dp_pkg::nodes_at(LANES, l - 1);
         always_ff @(posedge clk) begin
            for (int i = 0; i < CNT; i++) begin
               if (2*i + 1 < PREV) node[i] <= g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
               else                node[i] <= g_lvl[l-1].node[2*i];   // odd operand rides along
            end
            sb <= g_lvl[l-1].sb;
         end
         always_ff @(posedge clk) begin
            if (rst) v <= 1'b0;
            else     v <= g_lvl[l-1].v;
         end
      end
   end

   assign sum_o = g_lvl[LVLS].node[0];
   assign sb_o  = g_lvl[LVLS].sb;
   assign vld_o = g_lvl[LVLS].v;

endmodule

// File: rtl/dp_bias_relu.sv
module dp_bias_relu #(
   parameter int SW = 20,
   parameter int BW = 16,
   parameter int OW = 16,
   localparam int XW = dp_pkg::max_i(dp_pkg::max_i(SW, BW) + 1, OW + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 vld_i,
   input  logic signed [SW-1:0] sum_i,
   input  logic [BW-1:0]        bias_i,
   output logic                 vld_o,
   output logic [OW-1:0]        res_o
);

   localparam logic signed [OW:0] LIMIT = {1'b0, {OW{1'b1}}};

   logic signed [XW-1:0] total;

   always_comb begin
      total = XW'(sum_i) + XW'($signed(bias_i));
   end

   always_ff @(posedge clk) begin
      if (total < 0)          res_o <= '0;
      else if (total > LIMIT) res_o <= {OW{1'b1}};
      else                    res_o <= total[OW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

endmodule

// File: rtl/dotprod_pipe.sv
module dotprod_pipe #(
   parameter int LANES = 9,
   parameter int AW    = 8,
   parameter int WW    = 8,
   parameter int BW    = 16,
   parameter int OW    = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_vld,
   input  logic [LANES*AW-1:0] in_act,
   input  logic [LANES*WW-1:0] in_wgt,
   input  logic [BW-1:0]       in_bias,
   output logic                out_vld,
   output logic [OW-1:0]       out_data
);

   localparam int PW   = AW + WW;
   localparam int LVLS = $clog2(LANES);
   localparam int SW   = PW + LVLS;

   if (LANES < 1) begin : g_bad_lanes
      $error("dotprod_pipe: LANES must be at least 1");
   end
   if (AW < 2 || WW < 2) begin : g_bad_width
      $error("dotprod_pipe: operand widths must be at least 2");
   end
   if (BW < 1 || OW < 1) begin : g_bad_out
      $error("dotprod_pipe: bias and output widths must be positive");
   end

   // capture stage
   logic                ld_vld;
   logic [LANES*AW-1:0] ld_act;
   logic [LANES*WW-1:0] ld_wgt;
   logic [BW-1:0]       ld_bias;

   always_ff @(posedge clk) begin
      ld_act  <= in_act;
      ld_wgt  <= in_wgt;
      ld_bias <= in_bias;
   end

   always_ff @(posedge clk) begin
      if (rst) ld_vld <= 1'b0;
      else     ld_vld <= in_vld;
   end

   // multiply stage
   logic                mul_vld;
   logic [LANES*PW-1:0] mul_prod;
   logic [BW-1:0]       mul_bias;

   dp_mul_bank #(.LANES(LANES), .AW(AW), .WW(WW), .SBW(BW)) u_mul (
      .clk   (clk),
      .rst   (rst),
      .vld_i (ld_vld),
      .act_i (ld_act),
      .wgt_i (ld_wgt),
      .sb_i  (ld_bias),
      .vld_o (mul_vld),
      .prod_o(mul_prod),
      .sb_o  (mul_bias)
   );

   // reduction tree
   logic                 tr_vld;
   logic signed [SW-1:0] tr_sum;
   logic [BW-1:0]        tr_bias;

   dp_add_tree #(.LANES(LANES), .IW(PW), .SBW(BW)) u_tree (
      .clk  (clk),
      .rst  (rst),
      .vld_i(mul_vld),
      .opd_i(mul_prod),
      .sb_i (mul_bias),
      .vld_o(tr_vld),
      .sum_o(tr_sum),
      .sb_o (tr_bias)
   );

   // bias, rectifier, clamp
   dp_bias_relu #(.SW(SW), .BW(BW), .OW(OW)) u_fin (
      .clk   (clk),
      .rst   (rst),
      .vld_i (tr_vld),
      .sum_i (tr_sum),
      .bias_i(tr_bias),
      .vld_o (out_vld),
      .res_o (out_data)
   );

endmodule

// File: rtl/dotprod_pipe_chk.sv
module dotprod_pipe_chk #(
   parameter int LANES = 9,
   parameter int OW    = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          in_vld,
   input logic          out_vld,
   input logic [OW-1:0] out_data
);

   localparam int LAT = 3 + $clog2(LANES);

   logic [LAT-1:0] vhist;
   int             inflight;

   always_ff @(posedge clk) begin
      if (rst) begin
         vhist    <= '0;
         inflight <= 0;
      end else begin
         vhist    <= {vhist[LAT-2:0], in_vld};
         inflight <= inflight + int'(in_vld) - int'(out_vld);
      end
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
      out_vld == vhist[LAT-1]);                                            // R3

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> !out_vld);                                                   // R8

   AST_NO_ORPHAN: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> inflight > 0);                                           // R7

   AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
      inflight <= LAT);                                                    // R2

   AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> !$isunknown(out_data));                                  // R1

endmodule

bind dotprod_pipe dotprod_pipe_chk #(.LANES(LANES), .OW(OW)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .in_vld  (in_vld),
   .out_vld (out_vld),
   .out_data(out_data)
);

// File: tb/tb_dotprod_pipe.sv
module tb_dotprod_pipe;

   localparam int N   = 9;
   localparam int AW  = 8;
   localparam int WW  = 8;
   localparam int BW  = 16;
   localparam int OW  = 16;
   localparam int LAT = 3 + $clog2(N);
   localparam longint MAXV = (longint'(1) << OW) - 1;

   logic            clk = 1'b0;
   logic            rst;
   logic            in_vld;
   logic [N*AW-1:0] in_act;
   logic [N*WW-1:0] in_wgt;
   logic [BW-1:0]   in_bias;
   logic            out_vld;
   logic [OW-1:0]   out_data;

   always #2 clk = ~clk;

   dotprod_pipe #(.LANES(N), .AW(AW), .WW(WW), .BW(BW), .OW(OW)) dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_act(in_act), .in_wgt(in_wgt),
      .in_bias(in_bias), .out_vld(out_vld), .out_data(out_data)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int     av [N];
   int     wv [N];
   longint exp_q [$];
   int     due_q [$];
   string  tag_q [$];
   int     n_chk = 0;
   int     n_fail = 0;
   bit     done = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint got, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, expv);
      end
   endtask

   // driver: present one group and push its expected result
   task automatic fire(input int b, input string tag);
      longint s;
      @(negedge clk); #1;
      s = b;
      for (int i = 0; i < N; i++) begin
         in_act[i*AW +: AW] = AW'(av[i]);
         in_wgt[i*WW +: WW] = WW'(wv[i]);
         s += longint'(av[i]) * longint'(wv[i]);
      end
      in_bias = BW'(b);
      in_vld  = 1'b1;
      if (s < 0)    s = 0;
      if (s > MAXV) s = MAXV;
      exp_q.push_back(s);
      due_q.push_back(cyc + LAT);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n, input bit junk, input bit chk);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); #1;
         in_vld = 1'b0;
         if (junk) begin
            in_act  = {N{8'($urandom_range(0, 255))}};
            in_wgt  = {N{8'($urandom_range(0, 255))}};
            in_bias = 16'($urandom_range(0, 65535));
         end
         if (chk) check(out_vld == 1'b0, "R7", "output while idle", longint'(out_vld), 0);
      end
   endtask

   task automatic set_all(input int a, input int w);
      for (int i = 0; i < N; i++) begin
         av[i] = a;
         wv[i] = w;
      end
   endtask

   // monitor: compare results against the scoreboard
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_vld) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7", "unexpected output", longint'(out_data), -1);
            end else begin
               check(longint'(out_data) == exp_q[0], tag_q[0], "result",
                     longint'(out_data), exp_q[0]);
               check(cyc == due_q[0], "R3", "latency", cyc, due_q[0]);
               void'(exp_q.pop_front());
               void'(due_q.pop_front());
               void'(tag_q.pop_front());
            end
         end else if (due_q.size() != 0 && cyc > due_q[0]) begin
            check(1'b0, "R3", "missing output", cyc, due_q[0]);
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected 0", cyc);
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_vld = 1'b0; in_act = '0; in_wgt = '0; in_bias = '0;
      repeat (3) @(negedge clk);
      check(out_vld == 1'b0, "R8", "reset state", longint'(out_vld), 0);
      #1 rst = 1'b0;

      // R1: basic sum, lane weights 1..9
      for (int i = 0; i < N; i++) begin av[i] = 1; wv[i] = i + 1; end
      fire(0, "R1");
      set_all(3, -2); av[4] = 7; fire(100, "R1");
      idle(LAT + 2, 0, 0);

      // R9: lane placement and signedness
      set_all(0, 0); av[0] = -3; wv[0] = 5; fire(40, "R9");
      set_all(0, 0); av[N-1] = 11; wv[N-1] = -7; fire(200, "R9");
      set_all(0, 0); av[4] = -128; wv[4] = -128; fire(0, "R9");
      idle(LAT + 2, 0, 0);

      // R4, R5, R6: rectifier and clamp edges
      set_all(-5, 3); fire(0, "R4");
      set_all(0, 0); fire(-1, "R4");
      set_all(-128, -128); fire(0, "R5");
      set_all(0, 0); fire(0, "R6");
      set_all(0, 0); av[0] = 127; wv[0] = 127; av[1] = 127; wv[1] = 127;
      av[2] = 127; wv[2] = 127; av[3] = 127; wv[3] = 127;
      fire(1019, "R6");
      fire(1020, "R6");
      idle(LAT + 2, 0, 0);

      // R2: back-to-back burst
      for (int g = 0; g < 24; g++) begin
         for (int i = 0; i < N; i++) begin
            av[i] = int'($urandom_range(0, 255)) - 128;
            wv[i] = int'($urandom_range(0, 255)) - 128;
         end
         fire(int'($urandom_range(0, 8000)) - 4000, "R2");
      end
      idle(LAT + 2, 0, 0);

      // R7: junk on buses with in_vld low
      idle(12, 1, 1);

      // R8: reset with groups in flight
      set_all(2, 2); fire(0, "R8"); fire(1, "R8"); fire(2, "R8");
      @(negedge clk); #1;
      in_vld = 1'b0; rst = 1'b1;
      exp_q.delete(); due_q.delete(); tag_q.delete();
      @(negedge clk); #1;
      rst = 1'b0;
      for (int k = 0; k < LAT + 2; k++) begin
         @(negedge clk); #1;
         check(out_vld == 1'b0, "R8", "stale output after reset", longint'(out_vld), 0);
      end

      // recovery burst after reset
      for (int g = 0; g < 6; g++) begin
         set_all(g, g + 1);
         fire(g * 10 - 20, "R2");
      end
      idle(LAT + 3, 0, 0);
      check(exp_q.size() == 0, "R3", "drained queue", exp_q.size(), 0);

      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule